// File: doc/BRIEF.md
# Paged RAM Disk Window Controller

This block is a bus slave that exposes a large word memory through a 512-byte window in the I/O page. The window starts at a base chosen by a 5-bit setting. Its first 256 bytes hold a single page register, which answers at every even address of that half. Its second 256 bytes are a data buffer. Software writes the page register to pick which slice of the memory the buffer shows. It then reads or writes buffer words directly, one bus word at a time.

Every stored byte keeps an even-parity bit. Memory that was never written starts with poisoned parity, so software must clear the disk with zeros before using it. A parity error seen on any enabled byte lane of a buffer read raises a sticky flag. The flag reads back in bit 15 of the page register, and any write to the page register clears it.

Requests enter on a valid/ready channel. Reads return data on a valid/ready response channel with a one-entry output register. A request is accepted only while that register is empty or being drained. So `req_ready` falls while a response waits with `rsp_ready` low, and an unaccepted request must be held unchanged. Writes and unclaimed accesses return no response.

Top module: `pgwin_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and a page register read returns 0x0000.
- R2: A request with `req_iopage` low is accepted but ignored: a read gets no response, and a write changes neither storage nor the page register.
- R3: The window covers 512 bytes starting at byte offset base×256 of the I/O page. The first 256 bytes are the page register, and every even address in that half reaches the same register. The next 256 bytes are the buffer. Accesses outside the window are ignored.
- R4: A page register write stores data bits 7:4 into page bits 3:0 when `req_be[0]` is set, and data bits 15:8 into page bits 11:4 when `req_be[1]` is set. A read returns {flag, page[10:0], 4'b0000}.
- R5: The buffer word index is {page, addr[7:1]}. Address bit 7 is the bank bit. Page bits above the configured memory depth fold onto lower pages.
- R6: A buffer write updates only the byte lanes whose `req_be` bit is set (bit 0 selects data bits 7:0, bit 1 selects data bits 15:8), together with their parity bits.
- R7: Each written byte stores even parity. Bytes never written read as 0x00 with bad parity. Only the lanes enabled on a buffer read are checked.
- R8: A parity error on a buffer read sets the flag, and the flag stays set until any page register write clears it.
- R9: A claimed read accepted at edge N gives `rsp_valid` and its data after edge N. While `rsp_ready` is low the response holds steady and `req_ready` is 0.
- R10: An accepted write never produces a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 5 | Window base, in units of 256 bytes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_iopage | input | 1 | Access targets the I/O page |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address, byte-address bits 12:1 |
| req_be | input | 2 | Byte lane enables |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 16 | Read data |

## Verification
Every result is due one edge after acceptance. Read data and `rsp_valid` appear after the accepting edge, and page and flag updates take effect at that same edge, so the next request already sees them. The bench drives each request at a falling edge and checks the response at the following falling edge. It observes page and flag changes through a page register read issued as the next request. For back-pressure, the bench holds `rsp_ready` low for several cycles. It then checks that the response stays fixed and that a waiting write takes effect only after release.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  localparam int LANES   = 2;
  localparam int LANE_W  = 8;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int PAGE_W  = 12;
  localparam int BASE_W  = 5;
  localparam int CSR_LSB = 4;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CSR  = 2'd1,
    TGT_BUF  = 2'd2
  } tgt_e;
endpackage

// File: rtl/pgwin_decode.sv
module pgwin_decode
  import pgwin_pkg::*;
(
  input  logic              iopage,
  input  logic [12:8]       win_addr,
  input  logic [BASE_W-1:0] base,
  output tgt_e              tgt
);
  logic [BASE_W-1:0] offset;

  always_comb begin
    offset = win_addr - base;
    tgt    = TGT_NONE;
    if (iopage) begin
      if (offset == BASE_W'(0))      tgt = TGT_CSR;
      else if (offset == BASE_W'(1)) tgt = TGT_BUF;
    end
  end
endmodule

// File: rtl/pgwin_page_reg.sv
module pgwin_page_reg
  import pgwin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [LANES-1:0]     be,
  input  logic [WORD_W-1:CSR_LSB] wdata,
  input  logic                 perr_set,
  output logic [PAGE_W-1:0]    page,
  output logic                 flag,
  output logic [WORD_W-1:0]    csr_rdata
);
  localparam int LO_W = LANE_W - CSR_LSB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page <= '0;
      flag <= 1'b0;
    end else if (wr_en) begin
      if (be[0]) page[LO_W-1:0]      <= wdata[LANE_W-1:CSR_LSB];
      if (be[1]) page[PAGE_W-1:LO_W] <= wdata[WORD_W-1:LANE_W];
      flag <= 1'b0;
    end else if (perr_set) begin
      flag <= 1'b1;
    end
  end

  assign csr_rdata = {flag, page[PAGE_W-2:0], CSR_LSB'(0)};
endmodule

// File: rtl/pgwin_store.sv
module pgwin_store
  import pgwin_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [LANES-1:0]  bad_par
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] data_mem [DEPTH];
    logic              par_mem  [DEPTH];
    logic [LANE_W-1:0] wbyte;

    // power-up contents: zero data with the wrong parity bit
    initial begin
      for (int i = 0; i < DEPTH; i++) begin
        data_mem[i] = '0;
        par_mem[i]  = 1'b1;
      end
    end

    assign wbyte = wdata[l*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (we && be[l]) begin
        data_mem[idx] <= wbyte;
        par_mem[idx]  <= ^wbyte;
      end
    end

    assign rdata[l*LANE_W +: LANE_W] = data_mem[idx];
    assign bad_par[l] = (^data_mem[idx]) ^ par_mem[idx];
  end
endmodule

// File: rtl/pgwin_ctrl.sv
module pgwin_ctrl
  import pgwin_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        base_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_iopage,
  input  logic              req_write,
  input  logic [12:1]       req_addr,
  input  logic [1:0]        req_be,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_rdata
);
  localparam int IDX_W = MEM_AW - 1;

  tgt_e              tgt;
  logic              accept;
  logic              csr_wr, buf_wr, buf_rd, perr_set;
  logic [PAGE_W-1:0] page_q;
  logic              perr_flag;
  logic [WORD_W-1:0] csr_rdata, mem_rdata;
  logic [LANES-1:0]  bad_par;
  logic [IDX_W-1:0]  widx;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  pgwin_decode u_decode (
    .iopage   (req_iopage),
    .win_addr (req_addr[12:8]),
    .base     (base_sel),
    .tgt      (tgt)
  );

  assign csr_wr   = accept &&  req_write && (tgt == TGT_CSR);
  assign buf_wr   = accept &&  req_write && (tgt == TGT_BUF);
  assign buf_rd   = accept && !req_write && (tgt == TGT_BUF);
  assign perr_set = buf_rd && |(bad_par & req_be);

  pgwin_page_reg u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (csr_wr),
    .be        (req_be),
    .wdata     (req_wdata[WORD_W-1:CSR_LSB]),
    .perr_set  (perr_set),
    .page      (page_q),
    .flag      (perr_flag),
    .csr_rdata (csr_rdata)
  );

  assign widx = IDX_W'({page_q, req_addr[7:1]});

  pgwin_store #(.IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .we      (buf_wr),
    .be      (req_be),
    .idx     (widx),
    .wdata   (req_wdata),
    .rdata   (mem_rdata),
    .bad_par (bad_par)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write && (tgt != TGT_NONE)) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= (tgt == TGT_CSR) ? csr_rdata : mem_rdata;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pgwin_ctrl_chk.sv
module pgwin_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  base_sel,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_iopage,
  input logic        req_write,
  input logic [12:1] req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_rdata,
  input logic [11:0] page_q,
  input logic        perr_flag
);
  logic [4:0] off;
  logic       acc, hit, csr_hit, csr_wr;

  assign off     = req_addr[12:8] - base_sel;
  assign acc     = req_valid && req_ready;
  assign hit     = req_iopage && (off < 5'd2);
  assign csr_hit = req_iopage && (off == 5'd0);
  assign csr_wr  = acc && req_write && csr_hit;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  p_rdrsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && hit |=> rsp_valid);

  p_noclaim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !hit |=> !rsp_valid);

  p_wrnoresp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write |=> !rsp_valid);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr |=> !perr_flag);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    perr_flag && !csr_wr |=> perr_flag);

  p_pagehold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr |=> $stable(page_q));
endmodule

bind pgwin_ctrl pgwin_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .base_sel   (base_sel),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_iopage (req_iopage),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .page_q     (page_q),
  .perr_flag  (perr_flag)
);

// File: tb/pgwin_ctrl_bench.sv
module pgwin_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  base_sel = 5'd9;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_iopage = 1'b0;
  logic        req_write = 1'b0;
  logic [12:1] req_addr = '0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pgwin_ctrl u_pgwin_ctrl (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_iopage(req_iopage),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        wr;
    logic        io;
    logic        rsp;
    logic [1:0]  be;
    logic [15:0] addr;
    logic [15:0] wd;
    logic [15:0] ex;
  } vec_t;

  // window base 9: register half 0x900-0x9FF, buffer half 0xA00-0xAFF
  localparam int NV = 37;
  localparam vec_t TBL [NV] = '{
    '{4'd1,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0900, 16'h0000, 16'h0000}, // R1 reset page
    '{4'd4,  1'b1, 1'b1, 1'b0, 2'b11, 16'h0902, 16'h0010, 16'h0000}, // R4 page 1
    '{4'd3,  1'b0, 1'b1, 1'b1, 2'b11, 16'h09FE, 16'h0000, 16'h0010}, // R3 alias
    '{4'd5,  1'b1, 1'b1, 1'b0, 2'b11, 16'h0A04, 16'h1234, 16'h0000}, // R5
    '{4'd5,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0A04, 16'h0000, 16'h1234}, // R5
    '{4'd5,  1'b1, 1'b1, 1'b0, 2'b11, 16'h0900, 16'h0020, 16'h0000}, // R5 page 2
    '{4'd7,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0A04, 16'h0000, 16'h0000}, // R7 poisoned
    '{4'd8,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0900, 16'h0000, 16'h8020}, // R8 flag set
    '{4'd8,  1'b1, 1'b1, 1'b0, 2'b11, 16'h0900, 16'h0020, 16'h0000}, // R8 clear
    '{4'd8,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0900, 16'h0000, 16'h0020}, // R8
    '{4'd6,  1'b1, 1'b1, 1'b0, 2'b01, 16'h0A04, 16'hABCD, 16'h0000}, // R6 low lane
    '{4'd7,  1'b0, 1'b1, 1'b1, 2'b01, 16'h0A04, 16'h0000, 16'h00CD}, // R7 lane 0 only
    '{4'd7,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0900, 16'h0000, 16'h0020}, // R7 no error
    '{4'd7,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0A04, 16'h0000, 16'h00CD}, // R7 high lane bad
    '{4'd8,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0900, 16'h0000, 16'h8020}, // R8
    '{4'd6,  1'b1, 1'b1, 1'b0, 2'b10, 16'h0A04, 16'h5600, 16'h0000}, // R6 high lane
    '{4'd8,  1'b1, 1'b1, 1'b0, 2'b11, 16'h0900, 16'h0020, 16'h0000}, // R8 clear
    '{4'd6,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0A04, 16'h0000, 16'h56CD}, // R6
    '{4'd8,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0900, 16'h0000, 16'h0020}, // R8
    '{4'd2,  1'b0, 1'b0, 1'b0, 2'b11, 16'h0A04, 16'h0000, 16'h0000}, // R2 no response
    '{4'd2,  1'b1, 1'b0, 1'b0, 2'b11, 16'h0A04, 16'hFFFF, 16'h0000}, // R2 ignored write
    '{4'd2,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0A04, 16'h0000, 16'h56CD}, // R2 unchanged
    '{4'd3,  1'b0, 1'b1, 1'b0, 2'b11, 16'h0B04, 16'h0000, 16'h0000}, // R3 above window
    '{4'd3,  1'b1, 1'b1, 1'b0, 2'b11, 16'h08FE, 16'h0070, 16'h0000}, // R3 below window
    '{4'd3,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0900, 16'h0000, 16'h0020}, // R3 unchanged
    '{4'd5,  1'b1, 1'b1, 1'b0, 2'b11, 16'h0900, 16'h0010, 16'h0000}, // R5 back to page 1
    '{4'd5,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0A04, 16'h0000, 16'h1234}, // R5
    '{4'd5,  1'b1, 1'b1, 1'b0, 2'b11, 16'h09A0, 16'h0090, 16'h0000}, // R5 page 9
    '{4'd5,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0A04, 16'h0000, 16'h1234}, // R5 fold
    '{4'd4,  1'b0, 1'b1, 1'b1, 2'b11, 16'h09A2, 16'h0000, 16'h0090}, // R4 readback
    '{4'd5,  1'b1, 1'b1, 1'b0, 2'b11, 16'h0A84, 16'h7777, 16'h0000}, // R5 bank bit
    '{4'd5,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0A04, 16'h0000, 16'h1234}, // R5
    '{4'd5,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0A84, 16'h0000, 16'h7777}, // R5
    '{4'd4,  1'b1, 1'b1, 1'b0, 2'b01, 16'h0900, 16'hFFF0, 16'h0000}, // R4 low lane
    '{4'd4,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0900, 16'h0000, 16'h00F0}, // R4
    '{4'd4,  1'b1, 1'b1, 1'b0, 2'b10, 16'h0900, 16'h1200, 16'h0000}, // R4 high lane
    '{4'd4,  1'b0, 1'b1, 1'b1, 2'b11, 16'h0900, 16'h0000, 16'h12F0}  // R4
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, accepted at the next rising edge, observed at the falling edge after
  task automatic issue(input logic wr, input logic io, input logic [1:0] be,
                       input logic [15:0] addr, input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_iopage = io; req_be = be;
    req_addr = addr[12:1]; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %h expected %h", 16'h0, 16'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle state during and after reset
    check("R1 rsp_valid in reset", {15'd0, rsp_valid}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", {15'd0, req_ready}, 16'h0001);
    check("R1 rsp_valid", {15'd0, rsp_valid}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].wr, TBL[i].io, TBL[i].be, TBL[i].addr, TBL[i].wd);
      // R10: writes and unclaimed accesses give no response
      check($sformatf("R%0d vec %0d valid", TBL[i].tag, i), {15'd0, rsp_valid}, {15'd0, TBL[i].rsp});
      if (TBL[i].rsp)
        check($sformatf("R%0d vec %0d data", TBL[i].tag, i), rsp_rdata, TBL[i].ex);
    end

    // R9: back-pressure holds the response and stalls a waiting write
    rsp_ready = 1'b0;
    issue(1'b0, 1'b1, 2'b11, 16'h0900, 16'h0000);
    check("R9 valid under stall", {15'd0, rsp_valid}, 16'h0001);
    check("R9 data under stall", rsp_rdata, 16'h12F0);
    check("R9 ready low", {15'd0, req_ready}, 16'h0000);
    req_valid = 1'b1; req_write = 1'b1; req_iopage = 1'b1; req_be = 2'b11;
    req_addr = 12'h480; req_wdata = 16'h0010;
    repeat (3) @(negedge clk);
    check("R9 held data", rsp_rdata, 16'h12F0);
    check("R9 held valid", {15'd0, rsp_valid}, 16'h0001);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 drained after write", {15'd0, rsp_valid}, 16'h0000);
    issue(1'b0, 1'b1, 2'b11, 16'h0900, 16'h0000);
    check("R9 stalled write landed", rsp_rdata, 16'h0010);

    // R7: a zero-filled word reads clean
    issue(1'b1, 1'b1, 2'b11, 16'h0A06, 16'h0000);
    issue(1'b0, 1'b1, 2'b11, 16'h0A06, 16'h0000);
    check("R7 filled word", rsp_rdata, 16'h0000);
    issue(1'b0, 1'b1, 2'b11, 16'h0900, 16'h0000);
    check("R7 no flag after fill", rsp_rdata, 16'h0010);

    // R1: reset in mid-run clears the page register
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rsp_valid after reset", {15'd0, rsp_valid}, 16'h0000);
    issue(1'b0, 1'b1, 2'b11, 16'h0900, 16'h0000);
    check("R1 page after reset", rsp_rdata, 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule